// File: doc/BRIEF.md
# Speculative Store Buffer with Load Forwarding

This block keeps the data of stores that have executed but have not yet retired, so that memory is only ever written by committed stores. Each slot remembers whether it is occupied, whether its store is still speculative, the store's address, its data word and an age tag that the pipeline assigns in program order. Executing stores claim a slot; a retiring store clears its speculative mark; a squashed store releases its slot. Committed slots leave one per cycle, oldest first, through a valid/ready write channel toward the data cache.

Loads probe the buffer combinationally with their address and their own age tag. Only stores older than the load are visible to it; among several such stores to the same address the one closest in age to the load supplies the value. On a hit the buffer value overrides the word the cache returned for the same load, and on a miss the cache word passes through unchanged. Age tags wrap around, and all comparisons are made modulo the tag width.

Top module: `ssb_top`

## Requirements
- R1: Out of reset no slot is occupied: `stFull` and `drainValid` are 0 and every load misses.
- R2: A store presented on `stValid` while a slot is free occupies one slot as speculative, and a later load to that address with a younger age tag hits and returns its data.
- R3: `stFull` is 1 exactly when all 8 slots are occupied; a store presented while `stFull` is 1 is dropped and no later load finds its address.
- R4: On a hit `ldData` carries the buffered word and `ldHit` is 1; on a miss `ldHit` is 0 and `ldData` equals `ldCacheData`.
- R5: Among occupied slots with the load's address and an age tag strictly older than the load's, the youngest supplies the data; stores with an equal or younger tag are ignored.
- R6: Age tags are 4 bits wide; tag a is older than tag b when bit 3 of (a − b) mod 16 is 1, so ages that wrap from 15 to 0 keep their order.
- R7: A squash with `abtValid` and a tag that matches a speculative slot frees that slot; later loads no longer see its data.
- R8: A commit with `cmtValid` and a matching tag clears the speculative mark; only occupied, non-speculative slots are offered on the drain channel.
- R9: The drain channel offers the oldest committed slot, holds address and data steady while `drainReady` is 0, moves one slot per accepted cycle, and frees the slot on acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| stValid | input | 1 | Executing store request |
| stAddr | input | 32 | Store address |
| stData | input | 32 | Store data word |
| stAge | input | 4 | Program-order tag of the store |
| stFull | output | 1 | All slots occupied; new stores are dropped |
| cmtValid | input | 1 | Store retirement request |
| cmtAge | input | 4 | Tag of the retiring store |
| abtValid | input | 1 | Store squash request |
| abtAge | input | 4 | Tag of the squashed store |
| ldAddr | input | 32 | Load probe address |
| ldAge | input | 4 | Program-order tag of the load |
| ldCacheData | input | 32 | Word read from the cache for the same load |
| ldHit | output | 1 | An older buffered store matched |
| ldData | output | 32 | Buffered word on a hit, cache word otherwise |
| drainValid | output | 1 | A committed slot is offered to the cache |
| drainReady | input | 1 | Cache accepts the offered write |
| drainAddr | output | 32 | Address of the offered write |
| drainData | output | 32 | Data of the offered write |

## Verification
The assertions assume that tags of live stores are unique and span fewer than 8 consecutive values, that commits arrive in program order and only for speculative slots, and that a squash never names a committed store; under those rules the offered drain slot cannot change while it waits. The stimulus assigns ages as a running count from a chosen base, including a base that wraps past 15, commits in that same order, and squashes only a store that was never committed. Loads are swept over every address class and every tag in the live window plus one beyond it.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  parameter int DEPTH = 8;
  parameter int AW    = 32;
  parameter int DW    = 32;
  parameter int AGEW  = 4;
  localparam int IDXW = $clog2(DEPTH);

  typedef logic [AGEW-1:0] age_t;

  typedef struct packed {
    logic [DEPTH-1:0] alloc;
    logic [DEPTH-1:0] commit;
    logic [DEPTH-1:0] squash;
    logic [DEPTH-1:0] release_;
    logic             drainVld;
    logic [IDXW-1:0]  drainIdx;
  } strobe_t;

  // a is older than b when (a - b) wraps negative
  function automatic logic isOlder(input age_t a, input age_t b);
    age_t diff;
    diff = a - b;
    return diff[AGEW-1];
  endfunction
endpackage

// File: rtl/ssb_ctrl.sv
module ssb_ctrl
  import ssb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             stValid,
  input  logic             cmtValid,
  input  age_t             cmtAge,
  input  logic             abtValid,
  input  age_t             abtAge,
  input  logic             drainReady,
  input  logic [DEPTH-1:0] entValid,
  input  logic [DEPTH-1:0] entSpec,
  input  age_t             entAge [DEPTH],
  output strobe_t          strobe,
  output logic             stFull
);
  logic [DEPTH-1:0] freeOneHot;
  logic             anyFree;
  logic             headFound;
  logic [IDXW-1:0]  headIdx;

  // lowest free slot
  always_comb begin
    freeOneHot = '0;
    anyFree    = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!entValid[i] && !anyFree) begin
        freeOneHot[i] = 1'b1;
        anyFree       = 1'b1;
      end
    end
  end

  // oldest committed slot
  always_comb begin
    headFound = 1'b0;
    headIdx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (entValid[i] && !entSpec[i]) begin
        if (!headFound || isOlder(entAge[i], entAge[headIdx])) begin
          headIdx   = IDXW'(i);
          headFound = 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.alloc    = (stValid && anyFree) ? freeOneHot : '0;
    strobe.drainVld = headFound;
    strobe.drainIdx = headIdx;
    for (int i = 0; i < DEPTH; i++) begin
      strobe.commit[i]   = cmtValid && entValid[i] && entSpec[i] && (entAge[i] == cmtAge);
      strobe.squash[i]   = abtValid && entValid[i] && entSpec[i] && (entAge[i] == abtAge);
      strobe.release_[i] = headFound && drainReady && (headIdx == IDXW'(i));
    end
  end

  assign stFull = !anyFree;

  // R3
  full_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stValid && stFull && !(headFound && drainReady) && !abtValid) |=> stFull);

  // R2
  alloc_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    stValid |-> $onehot0(strobe.alloc));
endmodule

// File: rtl/ssb_data.sv
module ssb_data
  import ssb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [AW-1:0]    stAddr,
  input  logic [DW-1:0]    stData,
  input  age_t             stAge,
  input  logic [AW-1:0]    ldAddr,
  input  age_t             ldAge,
  input  logic [DW-1:0]    ldCacheData,
  input  logic             drainReady,
  output logic             ldHit,
  output logic [DW-1:0]    ldData,
  output logic [AW-1:0]    drainAddr,
  output logic [DW-1:0]    drainData,
  output logic [DEPTH-1:0] entValid,
  output logic [DEPTH-1:0] entSpec,
  output age_t             entAge [DEPTH]
);
  logic [AW-1:0] entAddr [DEPTH];
  logic [DW-1:0] entData [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entValid[g] <= 1'b0;
        entSpec[g]  <= 1'b0;
      end else if (strobe.alloc[g]) begin
        entValid[g] <= 1'b1;
        entSpec[g]  <= 1'b1;
      end else begin
        if (strobe.commit[g])
          entSpec[g] <= 1'b0;
        if (strobe.squash[g] || strobe.release_[g])
          entValid[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (strobe.alloc[g]) begin
        entAddr[g] <= stAddr;
        entData[g] <= stData;
        entAge[g]  <= stAge;
      end
    end

    // R2
    alloc_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.alloc[g] |=> (entValid[g] && entSpec[g]));

    // R7
    squash_frees_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.squash[g] |=> !entValid[g]);
  end

  // forwarding: youngest matching store older than the load
  logic          bufHit;
  logic [DW-1:0] bufWord;
  age_t          bestAge;

  always_comb begin
    bufHit  = 1'b0;
    bufWord = '0;
    bestAge = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (entValid[i] && (entAddr[i] == ldAddr) && isOlder(entAge[i], ldAge)) begin
        if (!bufHit || isOlder(bestAge, entAge[i])) begin
          bufHit  = 1'b1;
          bufWord = entData[i];
          bestAge = entAge[i];
        end
      end
    end
  end

  assign ldHit     = bufHit;
  assign ldData    = bufHit ? bufWord : ldCacheData;
  assign drainAddr = entAddr[strobe.drainIdx];
  assign drainData = entData[strobe.drainIdx];

  // R8
  drain_committed_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.drainVld |-> (entValid[strobe.drainIdx] && !entSpec[strobe.drainIdx]));

  // R9
  drain_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.drainVld && !drainReady) |=>
      (strobe.drainVld && $stable(drainAddr) && $stable(drainData)));
endmodule

// File: rtl/ssb_top.sv
module ssb_top
  import ssb_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          stValid,
  input  logic [AW-1:0] stAddr,
  input  logic [DW-1:0] stData,
  input  age_t          stAge,
  output logic          stFull,
  input  logic          cmtValid,
  input  age_t          cmtAge,
  input  logic          abtValid,
  input  age_t          abtAge,
  input  logic [AW-1:0] ldAddr,
  input  age_t          ldAge,
  input  logic [DW-1:0] ldCacheData,
  output logic          ldHit,
  output logic [DW-1:0] ldData,
  output logic          drainValid,
  input  logic          drainReady,
  output logic [AW-1:0] drainAddr,
  output logic [DW-1:0] drainData
);
  strobe_t          strobe;
  logic [DEPTH-1:0] entValid;
  logic [DEPTH-1:0] entSpec;
  age_t             entAge [DEPTH];

  ssb_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .stValid(stValid),
    .cmtValid(cmtValid), .cmtAge(cmtAge),
    .abtValid(abtValid), .abtAge(abtAge),
    .drainReady(drainReady),
    .entValid(entValid), .entSpec(entSpec), .entAge(entAge),
    .strobe(strobe), .stFull(stFull)
  );

  ssb_data uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .stAddr(stAddr), .stData(stData), .stAge(stAge),
    .ldAddr(ldAddr), .ldAge(ldAge), .ldCacheData(ldCacheData),
    .drainReady(drainReady),
    .ldHit(ldHit), .ldData(ldData),
    .drainAddr(drainAddr), .drainData(drainData),
    .entValid(entValid), .entSpec(entSpec), .entAge(entAge)
  );

  assign drainValid = strobe.drainVld;
endmodule

// File: tb/tb_ssb_top.sv
`timescale 1ns/1ps
module tb_ssb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        stValid;
  logic [31:0] stAddr, stData;
  logic [3:0]  stAge;
  logic        stFull;
  logic        cmtValid, abtValid;
  logic [3:0]  cmtAge, abtAge;
  logic [31:0] ldAddr, ldCacheData;
  logic [3:0]  ldAge;
  logic        ldHit;
  logic [31:0] ldData;
  logic        drainValid, drainReady;
  logic [31:0] drainAddr, drainData;

  int testCount = 0;
  int failCount = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ssb_top dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic doStore(input logic [31:0] a, input logic [31:0] d, input logic [3:0] ag);
    @(negedge clk);
    stValid = 1'b1; stAddr = a; stData = d; stAge = ag;
    @(negedge clk);
    stValid = 1'b0;
  endtask

  task automatic doCommit(input logic [3:0] ag);
    @(negedge clk);
    cmtValid = 1'b1; cmtAge = ag;
    @(negedge clk);
    cmtValid = 1'b0;
  endtask

  task automatic doSquash(input logic [3:0] ag);
    @(negedge clk);
    abtValid = 1'b1; abtAge = ag;
    @(negedge clk);
    abtValid = 1'b0;
  endtask

  task automatic probe(input logic [31:0] a, input logic [3:0] ag, input int expIdx, input string req);
    ldAddr = a; ldAge = ag;
    #1;
    chk({req, " hit"}, {31'd0, ldHit}, {31'd0, expIdx >= 0});
    chk({req, " data"}, ldData, (expIdx >= 0) ? 32'hA000 + expIdx : ldCacheData);
  endtask

  task automatic runPass(input logic [3:0] base);
    for (int i = 0; i < 8; i++)
      doStore(32'h100 + (i % 3) * 4, 32'hA000 + i, base + 4'(i));
    @(negedge clk);
    chk("R3 full after 8", {31'd0, stFull}, 32'd1);
    doStore(32'h200, 32'hBAD0, base + 4'd8);
    probe(32'h200, base + 4'd9, -1, "R3 dropped store");
    // R5 R6 R4: sweep address classes and load ages
    for (int k = 0; k < 3; k++) begin
      for (int j = 0; j <= 8; j++) begin
        int e;
        e = -1;
        for (int i = 0; i < j; i++) if (i % 3 == k) e = i;
        probe(32'h100 + k * 4, base + 4'(j), e, "R5/R6 forward");
      end
    end
    // R7: squash store 7 (class 1)
    doSquash(base + 4'd7);
    probe(32'h104, base + 4'd8, 4, "R7 after squash");
    // R8: commit first three, drain gated by ready
    for (int i = 0; i < 3; i++) doCommit(base + 4'(i));
    #1;
    chk("R8 drain offered", {31'd0, drainValid}, 32'd1);
    chk("R9 oldest first addr", drainAddr, 32'h100);
    @(negedge clk);
    chk("R9 held data", drainData, 32'hA000);
    drainReady = 1'b1;
    for (int m = 0; m < 3; m++) begin
      #1;
      chk("R9 drain order", drainData, 32'hA000 + m);
      @(negedge clk);
    end
    #1;
    chk("R8 speculative not drained", {31'd0, drainValid}, 32'd0);
    chk("R3 full released", {31'd0, stFull}, 32'd0);
    drainReady = 1'b0;
    for (int i = 3; i < 7; i++) doCommit(base + 4'(i));
    drainReady = 1'b1;
    for (int m = 3; m < 7; m++) begin
      #1;
      chk("R9 drain order", drainData, 32'hA000 + m);
      chk("R9 drain addr", drainAddr, 32'h100 + (m % 3) * 4);
      @(negedge clk);
    end
    #1;
    chk("R9 empty after drain", {31'd0, drainValid}, 32'd0);
    drainReady = 1'b0;
    for (int k = 0; k < 3; k++) probe(32'h100 + k * 4, base + 4'd8, -1, "R9 slots freed");
  endtask

  initial begin
    rstN = 1'b0; stValid = 0; stAddr = 0; stData = 0; stAge = 0;
    cmtValid = 0; cmtAge = 0; abtValid = 0; abtAge = 0;
    ldAddr = 0; ldAge = 0; ldCacheData = 32'hC0DE_0001; drainReady = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 full at reset", {31'd0, stFull}, 32'd0);
    chk("R1 drain at reset", {31'd0, drainValid}, 32'd0);
    probe(32'h100, 4'd5, -1, "R1 miss at reset");
    // R2 single store forwarding, R4 cache override
    doStore(32'h300, 32'hA000 + 2, 4'd3);
    ldCacheData = 32'hC0DE_0002;
    probe(32'h300, 4'd4, 2, "R2/R4 buffer over cache");
    probe(32'h304, 4'd4, -1, "R4 miss passes cache");
    doSquash(4'd3);
    probe(32'h300, 4'd4, -1, "R7 squash single");
    runPass(4'd0);
    runPass(4'd12);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      failCount++;
      testCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule